// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and an 8K × 8 asynchronous static RAM. The host offers one single-byte read or write at a time over a valid/ready handshake. The block holds the address, and for a write the data, in its own registers. It then drives the RAM's two opposite-polarity chip selects, its active-low write and output strobes, and the tri-state controls of the shared data bus. Every strobe phase lasts a whole number of clocks. Each phase length is computed at elaboration by rounding up a nanosecond minimum divided by the clock period parameter.

A write lowers the write strobe while the address is stable. The block leaves the bus undriven until the RAM has released its outputs. It then drives the data long enough to meet the data setup time, and releases the bus on the same edge on which the write strobe rises. A short tail pads out the minimum write cycle. A read lowers the output strobe and waits until both the address access time and the output-enable access time have elapsed. It captures the byte on the edge that ends the wait and returns it with a one-cycle valid pulse. A turnaround phase follows, so that the RAM has released the bus before anyone else drives it.

A level request deselects the RAM for low power standby. When the request is dropped, the block holds ready low for one read-cycle recovery time before it accepts the next access. The same recovery follows reset.

Top module: `sram_seq_top`

## Requirements
- R1: Outside standby `sram_ce1_n` is 0 and `sram_ce2` is 1. In standby `sram_ce1_n` is 1 and `sram_ce2` is 0. Whenever the RAM is deselected, both strobes are high and `sram_dq_oe` is 0.
- R2: A read returns the byte most recently written to the same 13-bit address. This holds for addresses 0x0000 and 0x1FFF and for data patterns of all zeros and all ones.
- R3: During a write, `sram_we_n` stays low for at least ceil(150/P) consecutive clocks, where P is CLK_PERIOD_NS. Both chip selects stay active for the whole pulse.
- R4: `sram_dq_oe` rises no earlier than ceil(60/P) clocks after `sram_we_n` falls. It stays high with constant data for at least ceil(100/P) clocks before `sram_we_n` rises, and falls on the same edge on which `sram_we_n` rises.
- R5: From the fall of `sram_we_n` to the next cycle with `req_ready` high, at least ceil(200/P) clocks pass.
- R6: During a read, `sram_we_n` stays high, and `sram_oe_n` and the address are held for ceil(max(200,150)/P) clocks. The byte on `sram_dq_in` is captured at the edge that ends this wait. `rsp_valid` is then high for exactly one cycle, with the byte on `rsp_rdata`.
- R7: `sram_dq_oe` is never high within ceil(40/P) clocks after `sram_oe_n` rises.
- R8: `req_ready` is low while a strobe is active, and during standby and recovery. A request is taken only on a cycle with both `req_valid` and `req_ready` high; a request offered while ready is low leaves the RAM untouched.
- R9: `sleep_req` high while idle enters standby on the next edge. After `sleep_req` is seen low, `req_ready` returns after ceil(200/P)+1 edges. After reset release, it returns after ceil(200/P) edges.
- R10: `sram_oe_n` and `sram_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Level request for low-power standby |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Block accepts an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Captured read byte |
| sram_addr | output | 13 | RAM address lines |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output strobe |
| sram_dq_out | output | 8 | Data toward the RAM |
| sram_dq_oe | output | 1 | Enable of the data bus driver |
| sram_dq_in | input | 8 | Data from the RAM bus |

## Verification
The assertions assume that the host keeps `req_write`, `req_addr` and `req_wdata` stable only across the single accepting edge, and that `sleep_req` is an ordinary synchronous level. The bench drives every input on the falling edge and lets each request go after one accepted cycle. The bench's RAM model returns a marker byte unless the address and output-enable timing has elapsed. It stores a corrupted byte unless the write data was held long enough, so early capture or short data setup shows up as a wrong byte in the scoreboard. No test byte equals the marker value 0x5A.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_WAKE,
      ST_IDLE,
      ST_STANDBY,
      ST_WR_REL,
      ST_WR_DRV,
      ST_WR_TAIL,
      ST_RD_ACC,
      ST_RD_TURN
   } seq_state_e;

   // nanoseconds to whole clocks, rounded up
   function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period);
      return (ns + period - 1) / period;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_dp.sv
module sram_seq_dp #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] bus_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rvalid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= in_addr;
         wdata_q <= in_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= capture;
         if (capture)
            rdata_q <= bus_in;
      end
   end

   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_q |=> !rvalid_q);  // R6

endmodule

// File: rtl/sram_seq_ctl.sv
module sram_seq_ctl
   import sram_seq_pkg::*;
#(
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned REL_CYC = 6,
   parameter int unsigned DRV_CYC = 12,
   parameter int unsigned TAIL_CYC = 2,
   parameter int unsigned ACC_CYC = 20,
   parameter int unsigned TURN_CYC = 4,
   parameter int unsigned REC_CYC = 20,
   parameter int unsigned WP_CYC  = 15,
   parameter int unsigned DW_CYC  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   input  logic accept,
   input  logic is_write,
   output logic ready,
   output logic capture,
   output logic ce_on,
   output logic we_n,
   output logic oe_n,
   output logic dq_oe
);

   localparam int unsigned MON_W = 16;
   localparam logic [MON_W-1:0] MON_MAX = '1;

   seq_state_e       state_q, state_d;
   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;

   sram_seq_timer #(
      .CNT_W  (CNT_W),
      .RST_VAL(REC_CYC - 1)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .done    (tmr_done)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      unique case (state_q)
         ST_WAKE: if (tmr_done) state_d = ST_IDLE;
         ST_IDLE: begin
            if (sleep) begin
               state_d = ST_STANDBY;
            end else if (accept) begin
               tmr_load = 1'b1;
               if (is_write) begin
                  state_d = ST_WR_REL;
                  tmr_val = CNT_W'(REL_CYC - 1);
               end else begin
                  state_d = ST_RD_ACC;
                  tmr_val = CNT_W'(ACC_CYC - 1);
               end
            end
         end
         ST_STANDBY: if (!sleep) begin
            state_d  = ST_WAKE;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(REC_CYC - 1);
         end
         ST_WR_REL: if (tmr_done) begin
            state_d  = ST_WR_DRV;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(DRV_CYC - 1);
         end
         ST_WR_DRV: if (tmr_done) begin
            state_d  = ST_WR_TAIL;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TAIL_CYC - 1);
         end
         ST_WR_TAIL: if (tmr_done) state_d = ST_IDLE;
         ST_RD_ACC: if (tmr_done) begin
            state_d  = ST_RD_TURN;
            capture  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TURN_CYC - 1);
         end
         ST_RD_TURN: if (tmr_done) state_d = ST_IDLE;
         default: state_d = ST_WAKE;
      endcase
   end

   // strobes come straight from flops, decoded from the next state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_WAKE;
         ce_on   <= 1'b1;
         we_n    <= 1'b1;
         oe_n    <= 1'b1;
         dq_oe   <= 1'b0;
      end else begin
         state_q <= state_d;
         ce_on   <= (state_d != ST_STANDBY);
         we_n    <= !((state_d == ST_WR_REL) || (state_d == ST_WR_DRV));
         oe_n    <= (state_d != ST_RD_ACC);
         dq_oe   <= (state_d == ST_WR_DRV);
      end
   end

   assign ready = (state_q == ST_IDLE) && !sleep;

   // run-length monitors for the timing properties
   logic [MON_W-1:0] we_lo_run, drv_run, oe_hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_run <= '0;
         drv_run   <= '0;
         oe_hi_run <= MON_MAX;
      end else begin
         we_lo_run <= we_n  ? '0 : ((we_lo_run == MON_MAX) ? MON_MAX : we_lo_run + 1'b1);
         drv_run   <= !dq_oe ? '0 : ((drv_run == MON_MAX) ? MON_MAX : drv_run + 1'b1);
         oe_hi_run <= !oe_n ? '0 : ((oe_hi_run == MON_MAX) ? MON_MAX : oe_hi_run + 1'b1);
      end
   end

   AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (we_lo_run >= MON_W'(WP_CYC)));  // R3
   AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> ce_on);  // R3
   AST_DRIVE_LATE_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> (we_lo_run >= MON_W'(REL_CYC)));  // R4
   AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (drv_run >= MON_W'(DW_CYC)));  // R4
   AST_RELEASE_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> !dq_oe);  // R4
   AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (oe_hi_run >= MON_W'(TURN_CYC)));  // R7
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));  // R10
   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_on |-> (we_n && oe_n && !dq_oe));  // R1
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !oe_n) |-> !ready);  // R8

endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 13,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned T_WP_NS       = 150,
   parameter int unsigned T_DW_NS       = 100,
   parameter int unsigned T_CW_NS       = 180,
   parameter int unsigned T_WC_NS       = 200,
   parameter int unsigned T_WZ_NS       = 60,
   parameter int unsigned T_AA_NS       = 200,
   parameter int unsigned T_OE_NS       = 150,
   parameter int unsigned T_OHZ_NS      = 40,
   parameter int unsigned T_RC_NS       = 200,
   parameter bit          STANDBY_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce1_n,
   output logic              sram_ce2,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);

   localparam int unsigned WP_CYC  = ns_to_clk(T_WP_NS,  CLK_PERIOD_NS);
   localparam int unsigned DW_CYC  = ns_to_clk(T_DW_NS,  CLK_PERIOD_NS);
   localparam int unsigned CW_CYC  = ns_to_clk(T_CW_NS,  CLK_PERIOD_NS);
   localparam int unsigned WC_CYC  = ns_to_clk(T_WC_NS,  CLK_PERIOD_NS);
   localparam int unsigned WZ_CYC  = ns_to_clk(T_WZ_NS,  CLK_PERIOD_NS);
   localparam int unsigned AA_CYC  = ns_to_clk(T_AA_NS,  CLK_PERIOD_NS);
   localparam int unsigned OE_CYC  = ns_to_clk(T_OE_NS,  CLK_PERIOD_NS);
   localparam int unsigned OHZ_CYC = ns_to_clk(T_OHZ_NS, CLK_PERIOD_NS);
   localparam int unsigned RC_CYC  = ns_to_clk(T_RC_NS,  CLK_PERIOD_NS);

   // phase lengths, each at least one clock
   localparam int unsigned REL_CYC  = umax(WZ_CYC, 1);
   localparam int unsigned DRV_CYC  = umax(umax(DW_CYC, 1),
                                      umax((WP_CYC > REL_CYC) ? WP_CYC - REL_CYC : 0,
                                           (CW_CYC > REL_CYC) ? CW_CYC - REL_CYC : 0));
   localparam int unsigned TAIL_CYC = umax(1, (WC_CYC > REL_CYC + DRV_CYC) ?
                                              WC_CYC - REL_CYC - DRV_CYC : 0);
   localparam int unsigned ACC_CYC  = umax(umax(AA_CYC, OE_CYC), 1);
   localparam int unsigned TURN_CYC = umax(OHZ_CYC, 1);
   localparam int unsigned REC_CYC  = umax(RC_CYC, 1);
   localparam int unsigned MAX_CYC  = umax(umax(umax(REL_CYC, DRV_CYC), umax(TAIL_CYC, ACC_CYC)),
                                      umax(TURN_CYC, REC_CYC));
   localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("CLK_PERIOD_NS must be nonzero");
   end
   if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
      $error("ADDR_W and DATA_W must be nonzero");
   end
   if (CNT_W > 16) begin : g_bad_count
      $error("phase length exceeds monitor range");
   end

   logic sleep_int;
   if (STANDBY_EN) begin : g_standby
      assign sleep_int = sleep_req;
   end else begin : g_no_standby
      assign sleep_int = 1'b0;
   end

   logic accept, capture, ce_on;

   assign accept = req_valid && req_ready;

   sram_seq_ctl #(
      .CNT_W   (CNT_W),
      .REL_CYC (REL_CYC),
      .DRV_CYC (DRV_CYC),
      .TAIL_CYC(TAIL_CYC),
      .ACC_CYC (ACC_CYC),
      .TURN_CYC(TURN_CYC),
      .REC_CYC (REC_CYC),
      .WP_CYC  (WP_CYC),
      .DW_CYC  (DW_CYC)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep   (sleep_int),
      .accept  (accept),
      .is_write(req_write),
      .ready   (req_ready),
      .capture (capture),
      .ce_on   (ce_on),
      .we_n    (sram_we_n),
      .oe_n    (sram_oe_n),
      .dq_oe   (sram_dq_oe)
   );

   sram_seq_dp #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .in_addr (req_addr),
      .in_wdata(req_wdata),
      .capture (capture),
      .bus_in  (sram_dq_in),
      .addr_q  (sram_addr),
      .wdata_q (sram_dq_out),
      .rdata_q (rsp_rdata),
      .rvalid_q(rsp_valid)
   );

   assign sram_ce1_n = !ce_on;
   assign sram_ce2   = ce_on;

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n || !sram_oe_n) && !accept |=> $stable(sram_addr));  // R6

endmodule

// File: tb/sram_seq_top_test.sv
module sram_seq_top_test;

   localparam int unsigned CLK_NS = 10;
   localparam int unsigned WZ  = (60  + CLK_NS - 1) / CLK_NS;
   localparam int unsigned WP  = (150 + CLK_NS - 1) / CLK_NS;
   localparam int unsigned DW  = (100 + CLK_NS - 1) / CLK_NS;
   localparam int unsigned WC  = (200 + CLK_NS - 1) / CLK_NS;
   localparam int unsigned AA  = (200 + CLK_NS - 1) / CLK_NS;
   localparam int unsigned OEA = (150 + CLK_NS - 1) / CLK_NS;
   localparam int unsigned OHZ = (40  + CLK_NS - 1) / CLK_NS;
   localparam int unsigned RC  = (200 + CLK_NS - 1) / CLK_NS;
   localparam logic [7:0] MARK = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_req = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [12:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [12:0] sram_addr;
   logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [7:0]  sram_dq_out, sram_dq_in;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS / 2) clk = ~clk;

   sram_seq_top #(.CLK_PERIOD_NS(CLK_NS)) uut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- RAM model, counted in clocks ----------------
   logic [7:0] mem [int];
   logic [7:0] shadow [int];
   logic [7:0] exp_q [$];
   int addr_run = 0, oe_lo = 0, we_lo = 0, oe_hi = 1000, drv_run = 0, wc_run = 0;
   logic [12:0] prev_addr = '0;
   logic [7:0]  held_d = '0;
   logic        held_ok = 1'b0, prev_we = 1'b1, prev_rsp = 1'b0, wc_on = 1'b0, prev_oe = 1'b0;
   logic        sel;

   assign sel = !sram_ce1_n && sram_ce2;

   always_comb begin
      if (sel && sram_we_n && !sram_oe_n && addr_run >= int'(AA) && oe_lo >= int'(OEA))
         sram_dq_in = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
      else
         sram_dq_in = MARK;
   end

   always @(negedge clk) if (rst_n) begin
      addr_run  = (!sel || sram_addr != prev_addr) ? 1 : addr_run + 1;
      prev_addr = sram_addr;
      oe_lo     = sram_oe_n ? 0 : oe_lo + 1;
      oe_hi     = sram_oe_n ? oe_hi + 1 : 0;
      we_lo     = sram_we_n ? we_lo : we_lo + 1;
      if (!sram_we_n && prev_we) wc_on = 1'b1;
      if (wc_on && !req_ready) wc_run++;

      // writes
      if (!sram_we_n) begin
         if (sram_dq_oe) begin
            if (!prev_oe) check(we_lo > int'(WZ), "R4", "drive start after WE fall", we_lo, WZ + 1);
            if (held_ok && sram_dq_out == held_d) drv_run++;
            else begin held_d = sram_dq_out; drv_run = 1; held_ok = 1'b1; end
         end else held_ok = 1'b0;
         check(sel, "R3", "chip selected during write pulse", sel, 1);
      end
      if (sram_we_n && !prev_we) begin
         check(we_lo >= int'(WP), "R3", "WE low length", we_lo, WP);
         check(drv_run >= int'(DW), "R4", "data setup length", drv_run, DW);
         check(!sram_dq_oe, "R4", "bus released with WE rise", sram_dq_oe, 0);
         mem[int'(sram_addr)] = (held_ok && drv_run >= int'(DW)) ? held_d : 8'hEE;
         held_ok = 1'b0; drv_run = 0; we_lo = 0;
      end
      if (wc_on && req_ready) begin
         check(wc_run >= int'(WC), "R5", "write cycle length", wc_run, WC);
         wc_on = 1'b0; wc_run = 0;
      end
      if (sram_dq_oe) begin
         check(sram_we_n == 1'b0, "R4", "drive only while WE low", sram_we_n, 0);
         check(oe_hi > int'(OHZ), "R7", "turnaround after OE rise", oe_hi, OHZ + 1);
      end
      if (!sram_we_n || !sram_oe_n) begin
         check(sram_we_n || sram_oe_n, "R10", "strobes exclusive", {sram_we_n, sram_oe_n}, 2);
         check(!req_ready, "R8", "ready low while busy", req_ready, 0);
      end
      if (!sel) check(sram_we_n && sram_oe_n && !sram_dq_oe, "R1", "quiet when deselected",
                      {sram_we_n, sram_oe_n, sram_dq_oe}, 6);

      // scoreboard monitor
      if (rsp_valid) begin
         check(!prev_rsp, "R6", "rsp_valid single cycle", prev_rsp, 0);
         if (exp_q.size() == 0) check(1'b0, "R6", "unexpected response", rsp_rdata, 0);
         else begin
            automatic logic [7:0] e = exp_q.pop_front();
            check(rsp_rdata == e, "R2", "read data", rsp_rdata, e);
         end
      end
      prev_rsp = rsp_valid;
      prev_we  = sram_we_n;
      prev_oe  = sram_dq_oe;
   end

   // ---------------- driver ----------------
   task automatic issue(input logic wr, input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      if (wr) shadow[int'(a)] = d;
      else exp_q.push_back(shadow[int'(a)]);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
      check(exp_q.size() == 0, "R6", "all reads answered", exp_q.size(), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // reset state (R1, R9)
      check(!sram_ce1_n && sram_ce2, "R1", "selected in reset recovery", {sram_ce1_n, sram_ce2}, 1);
      check(sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid && !req_ready, "R9",
            "reset outputs idle", {sram_we_n, sram_oe_n, sram_dq_oe, rsp_valid, req_ready}, 5'b11000);
      rst_n = 1'b1;
      n = 0;
      @(negedge clk);
      while (!req_ready && n < 1000) begin n++; @(negedge clk); end
      check(n == int'(RC) - 1, "R9", "recovery after reset", n, RC - 1);

      // writes and reads with distinct patterns (R2)
      issue(1'b1, 13'h0000, 8'h00);
      issue(1'b1, 13'h1FFF, 8'hFF);
      issue(1'b1, 13'h0AAA, 8'h55);
      issue(1'b1, 13'h1555, 8'hA5);
      issue(1'b0, 13'h0000, 8'h00);
      issue(1'b0, 13'h1FFF, 8'h00);
      issue(1'b0, 13'h0AAA, 8'h00);
      issue(1'b0, 13'h1555, 8'h00);
      // overwrite then read back at once
      issue(1'b1, 13'h0AAA, 8'h3C);
      issue(1'b0, 13'h0AAA, 8'h00);
      issue(1'b0, 13'h0AAA, 8'h00);
      for (int k = 0; k < 8; k++) issue(1'b1, 13'(k * 13'h0401), 8'(8'h11 * (k + 1)));
      for (int k = 7; k >= 0; k--) issue(1'b0, 13'(k * 13'h0401), 8'h00);
      issue(1'b1, 13'h0010, 8'h33);
      drain();

      // standby: enter, ignore a request, leave with recovery (R1, R8, R9)
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      sleep_req = 1'b1;
      @(negedge clk);
      check(sram_ce1_n && !sram_ce2, "R1", "deselected in standby", {sram_ce1_n, sram_ce2}, 2);
      check(!req_ready, "R9", "ready low in standby", req_ready, 0);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0010; req_wdata = 8'h77;
      repeat (5) @(negedge clk);
      check(sram_we_n && sram_ce1_n, "R8", "request ignored in standby", {sram_we_n, sram_ce1_n}, 3);
      req_valid = 1'b0;
      sleep_req = 1'b0;
      n = 0;
      @(negedge clk);
      while (!req_ready && n < 1000) begin n++; @(negedge clk); end
      check(n == int'(RC), "R9", "recovery after standby", n, RC);
      issue(1'b0, 13'h0010, 8'h00);
      drain();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule